// File: doc/BRIEF.md
# Dark-Frame Defect Pixel Scanner

This block hunts for stuck-bright sensor sites while the optics are shuttered. After a start command it empties its result list and then watches a pixel stream tagged with row and column counters. Pixels are judged two at a time, as horizontal pairs. A pair whose darker-than-dark level is too high is logged by position. When a frame yields more hits than the list can hold, the block raises its threshold by a host-chosen step. It then repeats the search on the next frame, until the hits fit or the pass budget runs out.

The host reads the result through a simple address/data port and uses the reported count. A level-type done flag and a two-bit error code tell it how the run ended. The run ends cleanly, runs out of passes while still over capacity, or stops early because the shutter was reported open.

Top module: `hotpix_hunter`

## Requirements
- R1: A pixel counts as defective only when its value is strictly greater than the current threshold; a value equal to the threshold is not a hit.
- R2: Columns are grouped in pairs (column 2k and 2k+1 form pair k); a pair with one or two defective pixels produces exactly one list entry, whose value is {row, k} with k in the low COL_W-1 bits.
- R3: Pairs lying in the first EDGE or the last EDGE columns of a line are never recorded.
- R4: The list holds CAP (32) entries, and the reported count never exceeds CAP.
- R5: When a frame produces more than CAP hits, the threshold grows by the step input, saturating at full scale, and the next frame is scanned again with an empty hit tally; entries are listed in stream order.
- R6: If pass MAX_PASS (128) still exceeds CAP, the run ends with error code 1 and count CAP, and the list holds the last CAP hits of that pass: slot i holds the most recent hit whose index modulo CAP is i.
- R7: A start command zeroes every list entry and the count before the first frame is examined.
- R8: If the shutter-open input is high while a frame is awaited or scanned, the run ends at once with error code 2 and count 0.
- R9: On completion, done goes high and stays high, with stable count and error code, until the next start; error code 0 means success.
- R10: The list read port returns the entry at the read address one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request (taken when idle or finished) |
| thr_init | input | PIX_W | Threshold for the first pass |
| thr_step | input | PIX_W | Threshold increment per retry |
| shutter_open | input | 1 | High when light may reach the sensor |
| pix_valid | input | 1 | Pixel strobe |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| pix_eof | input | 1 | Marks the last pixel of a frame |
| pix_row | input | ROW_W | Line counter of the current pixel |
| pix_col | input | COL_W | Column counter of the current pixel |
| pix_data | input | PIX_W | Pixel value |
| rd_addr | input | AW | List read address |
| rd_data | output | ROW_W+COL_W-1 | List entry {row, pair} |
| count | output | CNT_W | Number of valid entries |
| done | output | 1 | Run finished |
| err_code | output | 2 | 0 ok, 1 pass limit, 2 shutter open |

## Verification
A quiet frame gives an empty list. A sparse frame separates the strict compare, the merging of pairs and the edge masking, because it places hits on odd columns, on even columns, on both halves of one pair, exactly at the threshold and inside the masked margins. A graded ramp frame overflows on the first pass and fits a few passes later, so the number of frames consumed and the final list show whether the threshold really rises by the step. A fully bright frame never fits and exposes the pass limit and the circular retention of the last hits. The shutter input is raised both before any frame and partway through a scan.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_WAIT, ST_SCAN, ST_EVAL, ST_DONE, ST_ERR
  } hpx_state_e;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_OVER = 2'd1;
  localparam logic [1:0] ERR_SHUT = 2'd2;
endpackage

// File: rtl/hpx_pair_detect.sv
module hpx_pair_detect #(
  parameter int PIX_W    = 12,
  parameter int COL_W    = 11,
  parameter int LINE_PIX = 720,
  parameter int EDGE     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic [COL_W-1:0] pix_col,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [PIX_W-1:0] thr,
  output logic             hit,
  output logic [COL_W-2:0] pair_idx
);
  localparam logic [COL_W-2:0] LO_PAIR = (COL_W-1)'(EDGE / 2);
  localparam logic [COL_W-2:0] HI_PAIR = (COL_W-1)'((LINE_PIX - EDGE) / 2);

  logic [PIX_W-1:0] even_q;
  logic             in_zone;

  // Hold the even half of the pair until its odd partner arrives.
  always_ff @(posedge clk) begin
    if (rst) even_q <= '0;
    else if (pix_valid && !pix_col[0]) even_q <= pix_data;
  end

  assign pair_idx = pix_col[COL_W-1:1];
  assign in_zone  = (pair_idx >= LO_PAIR) && (pair_idx < HI_PAIR);
  assign hit      = pix_valid && pix_col[0] && in_zone &&
                    ((even_q > thr) || (pix_data > thr));
endmodule

// File: rtl/hpx_list_ram.sv
module hpx_list_ram #(
  parameter int DW    = 20,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl
  import hpx_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int ROW_W    = 10,
  parameter int COL_W    = 11,
  parameter int CAP      = 32,
  parameter int MAX_PASS = 128,
  parameter int AW       = $clog2(CAP),
  parameter int CNT_W    = $clog2(CAP + 1),
  parameter int EW       = ROW_W + COL_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PIX_W-1:0] thr_init,
  input  logic [PIX_W-1:0] thr_step,
  input  logic             shutter_open,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic             pix_eof,
  input  logic [ROW_W-1:0] pix_row,
  input  logic             hit,
  input  logic [COL_W-2:0] pair_idx,
  output logic [PIX_W-1:0] thr,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [EW-1:0]    wdata,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic [1:0]       err_code,
  output hpx_state_e       state
);
  localparam int HIT_W  = ROW_W + COL_W;
  localparam int PASS_W = $clog2(MAX_PASS + 1);
  localparam logic [AW-1:0]     LAST_SLOT = AW'(CAP - 1);
  localparam logic [HIT_W-1:0]  CAP_H     = HIT_W'(CAP);
  localparam logic [PASS_W-1:0] PASS_LIM  = PASS_W'(MAX_PASS);

  logic [AW-1:0]     clr_idx, wptr;
  logic [HIT_W-1:0]  hits;
  logic [PASS_W-1:0] pass;
  logic [PIX_W:0]    thr_sum;
  logic              take_start, scan_hit;

  assign take_start = start && (state == ST_IDLE || state == ST_DONE || state == ST_ERR);
  assign scan_hit   = (state == ST_SCAN) && hit && !shutter_open;
  assign thr_sum    = {1'b0, thr} + {1'b0, thr_step};

  assign we    = (state == ST_CLEAR) || scan_hit;
  assign waddr = (state == ST_CLEAR) ? clr_idx : wptr;
  assign wdata = (state == ST_CLEAR) ? '0 : {pix_row, pair_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      clr_idx  <= '0;
      wptr     <= '0;
      hits     <= '0;
      pass     <= '0;
      thr      <= '0;
      count    <= '0;
      done     <= 1'b0;
      err_code <= ERR_NONE;
    end else if (take_start) begin
      state    <= ST_CLEAR;
      clr_idx  <= '0;
      wptr     <= '0;
      hits     <= '0;
      pass     <= PASS_W'(1);
      thr      <= thr_init;
      count    <= '0;
      done     <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      case (state)
        ST_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == LAST_SLOT) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (shutter_open) begin
            state <= ST_ERR; err_code <= ERR_SHUT; done <= 1'b1;
          end else if (pix_valid && pix_sof) begin
            state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (shutter_open) begin
            state <= ST_ERR; err_code <= ERR_SHUT; done <= 1'b1;
          end else begin
            if (scan_hit) begin
              hits <= hits + 1'b1;
              wptr <= (wptr == LAST_SLOT) ? '0 : wptr + 1'b1;
            end
            if (pix_valid && pix_eof) state <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (hits <= CAP_H) begin
            state <= ST_DONE;
            count <= CNT_W'(hits);
            done  <= 1'b1;
          end else if (pass == PASS_LIM) begin
            state    <= ST_ERR;
            count    <= CNT_W'(CAP);
            err_code <= ERR_OVER;
            done     <= 1'b1;
          end else begin
            state <= ST_WAIT;
            pass  <= pass + 1'b1;
            hits  <= '0;
            wptr  <= '0;
            thr   <= thr_sum[PIX_W] ? '1 : thr_sum[PIX_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hotpix_hunter.sv
module hotpix_hunter
  import hpx_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int ROW_W    = 10,
  parameter int COL_W    = 11,
  parameter int LINE_PIX = 720,
  parameter int EDGE     = 8,
  parameter int CAP      = 32,
  parameter int MAX_PASS = 128,
  parameter int AW       = $clog2(CAP),
  parameter int CNT_W    = $clog2(CAP + 1),
  parameter int EW       = ROW_W + COL_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PIX_W-1:0] thr_init,
  input  logic [PIX_W-1:0] thr_step,
  input  logic             shutter_open,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic             pix_eof,
  input  logic [ROW_W-1:0] pix_row,
  input  logic [COL_W-1:0] pix_col,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [EW-1:0]    rd_data,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic [1:0]       err_code
);
  logic [PIX_W-1:0] thr;
  logic             hit, we;
  logic [COL_W-2:0] pair_idx;
  logic [AW-1:0]    waddr;
  logic [EW-1:0]    wdata;
  hpx_state_e       state;

  hpx_pair_detect #(.PIX_W(PIX_W), .COL_W(COL_W), .LINE_PIX(LINE_PIX), .EDGE(EDGE)) u_det (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_col(pix_col),
    .pix_data(pix_data), .thr(thr), .hit(hit), .pair_idx(pair_idx)
  );

  hpx_ctrl #(.PIX_W(PIX_W), .ROW_W(ROW_W), .COL_W(COL_W), .CAP(CAP),
             .MAX_PASS(MAX_PASS), .AW(AW), .CNT_W(CNT_W), .EW(EW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .thr_init(thr_init), .thr_step(thr_step),
    .shutter_open(shutter_open), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_eof(pix_eof), .pix_row(pix_row), .hit(hit), .pair_idx(pair_idx),
    .thr(thr), .we(we), .waddr(waddr), .wdata(wdata), .count(count),
    .done(done), .err_code(err_code), .state(state)
  );

  hpx_list_ram #(.DW(EW), .DEPTH(CAP), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/hpx_checker.sv
module hpx_checker
  import hpx_pkg::*;
#(
  parameter int CAP   = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             shutter_open,
  input logic             done,
  input logic [1:0]       err_code,
  input logic [CNT_W-1:0] count,
  input hpx_state_e       state
);
  p_count_cap_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(CAP));

  p_shutter_abort_r8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_WAIT || state == ST_SCAN) && shutter_open && !start)
      |=> (done && err_code == ERR_SHUT && count == '0));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(err_code) && $stable(count)));

  p_start_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (start && (state == ST_IDLE || state == ST_DONE || state == ST_ERR))
      |=> (!done && count == '0 && err_code == ERR_NONE));

  p_err_done_r6: assert property (@(posedge clk) disable iff (rst)
    (err_code != ERR_NONE) |-> done);
endmodule

bind hotpix_hunter hpx_checker #(.CAP(CAP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .shutter_open(shutter_open),
  .done(done), .err_code(err_code), .count(count), .state(state)
);

// File: tb/hotpix_hunter_test.sv
module hotpix_hunter_test;
  localparam int PIX_W = 12, ROW_W = 10, COL_W = 11;
  localparam int LINE = 48, ROWS = 4, EDGE = 8, CAP = 32, MAXP = 128;
  localparam int AW = 5, CNT_W = 6, EW = ROW_W + COL_W - 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [PIX_W-1:0] thr_init = '0, thr_step = '0, pix_data = '0;
  logic shutter_open = 1'b0, pix_valid = 1'b0, pix_sof = 1'b0, pix_eof = 1'b0;
  logic [ROW_W-1:0] pix_row = '0;
  logic [COL_W-1:0] pix_col = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [EW-1:0] rd_data;
  logic [CNT_W-1:0] count;
  logic done;
  logic [1:0] err_code;

  int checks = 0, errors = 0;
  int exp_e [CAP];
  int exp_cnt, exp_err, exp_pass, frames;

  always #10 clk = ~clk;

  hotpix_hunter #(.PIX_W(PIX_W), .ROW_W(ROW_W), .COL_W(COL_W), .LINE_PIX(LINE),
                  .EDGE(EDGE), .CAP(CAP), .MAX_PASS(MAXP)) uut (
    .clk(clk), .rst(rst), .start(start), .thr_init(thr_init), .thr_step(thr_step),
    .shutter_open(shutter_open), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_eof(pix_eof), .pix_row(pix_row), .pix_col(pix_col), .pix_data(pix_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count(count), .done(done), .err_code(err_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pval(input int pat, input int r, input int c);
    case (pat)
      1: begin
        if (r == 0 && (c < 8 || c >= 40)) return 4000;
        if (r == 0 && c == 39) return 150;
        if (r == 1 && c == 9) return 200;
        if (r == 2 && c == 10) return 200;
        if (r == 2 && c == 11) return 300;
        if (r == 3 && c == 20) return 100;
        return 10;
      end
      2: return ((r * LINE + c) * 53) % 1000 + 20;
      3: return 4000;
      default: return 10;
    endcase
  endfunction

  // Behavioural expectation of a whole run, built from the requirements.
  task automatic model(input int pat, input int thr0, input int step);
    int thr, hits, p;
    for (int i = 0; i < CAP; i++) exp_e[i] = 0;
    thr = thr0;
    exp_err = 0;
    for (p = 1; p <= MAXP; p++) begin
      int tmp [CAP];
      hits = 0;
      for (int i = 0; i < CAP; i++) tmp[i] = exp_e[i];
      for (int r = 0; r < ROWS; r++)
        for (int k = EDGE / 2; k < (LINE - EDGE) / 2; k++)
          if (pval(pat, r, 2 * k) > thr || pval(pat, r, 2 * k + 1) > thr) begin
            tmp[hits % CAP] = r * (1 << (COL_W - 1)) + k;
            hits++;
          end
      for (int i = 0; i < CAP; i++) exp_e[i] = tmp[i];
      if (hits <= CAP) begin
        exp_cnt = hits; exp_pass = p; return;
      end
      thr = (thr + step > 4095) ? 4095 : thr + step;
    end
    exp_err = 1; exp_cnt = CAP; exp_pass = MAXP;
  endtask

  task automatic send_frame(input int pat, input int shut);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < LINE; c++) begin
        @(negedge clk);
        pix_valid = 1'b1;
        pix_sof = (r == 0 && c == 0);
        pix_eof = (r == ROWS - 1 && c == LINE - 1);
        pix_row = ROW_W'(r);
        pix_col = COL_W'(c);
        pix_data = PIX_W'(pval(pat, r, c));
        if (shut == 2 && r == 2) shutter_open = 1'b1;
      end
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
  endtask

  task automatic run(input int pat, input int thr0, input int step, input int shut, input string tag);
    @(negedge clk);
    thr_init = PIX_W'(thr0); thr_step = PIX_W'(step);
    shutter_open = (shut == 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && count == 0, {tag, " R7 start clears"}, int'(count), 0);
    repeat (40) @(negedge clk);
    frames = 0;
    while (!done && frames < MAXP + 5) begin
      send_frame(pat, shut);
      frames++;
      repeat (3) @(negedge clk);
    end
    shutter_open = 1'b0;
  endtask

  task automatic check_list(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      rd_addr = AW'(i);
      @(negedge clk);
      chk(int'(rd_data) == exp_e[i], {tag, " R2 R10 entry"}, int'(rd_data), exp_e[i]);
    end
  endtask

  initial begin
    #3_800_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && err_code == 0 && count == 0, "reset R9", int'(done), 0);

    // R1 R2 R3: sparse frame, single pass.
    model(1, 100, 10);
    run(1, 100, 10, 0, "sparse");
    chk(done && err_code == 0, "sparse R9 done ok", int'(err_code), 0);
    chk(int'(count) == exp_cnt && exp_cnt == 3, "sparse R1 R3 count", int'(count), 3);
    chk(frames == 1, "sparse R5 one pass", frames, 1);
    check_list("sparse", 3);
    repeat (5) @(negedge clk);
    chk(done && int'(count) == 3, "sparse R9 hold", int'(count), 3);

    // R7: quiet frame after a populated run; entries wiped.
    model(0, 100, 10);
    run(0, 100, 10, 0, "quiet");
    chk(done && int'(count) == 0, "quiet R7 count", int'(count), 0);
    check_list("quiet R7", 4);

    // R5: ramp overflows, then fits after raises.
    model(2, 200, 150);
    run(2, 200, 150, 0, "ramp");
    chk(exp_pass > 1, "ramp R5 model retries", exp_pass, 2);
    chk(frames == exp_pass, "ramp R5 passes", frames, exp_pass);
    chk(err_code == 0 && int'(count) == exp_cnt, "ramp R4 count", int'(count), exp_cnt);
    check_list("ramp R5", exp_cnt);

    // R6: never fits, pass limit.
    model(3, 100, 1);
    run(3, 100, 1, 0, "bright");
    chk(frames == MAXP, "bright R6 passes", frames, MAXP);
    chk(int'(err_code) == 1, "bright R6 code", int'(err_code), 1);
    chk(int'(count) == CAP, "bright R4 R6 count", int'(count), CAP);
    check_list("bright R6", CAP);

    // R8: shutter open before any frame.
    run(0, 100, 10, 1, "shut0");
    chk(int'(err_code) == 2 && done, "shut0 R8 code", int'(err_code), 2);
    chk(frames == 0 && count == 0, "shut0 R8 no frame", frames, 0);

    // R8: shutter opens mid-scan.
    run(1, 100, 10, 2, "shut1");
    chk(int'(err_code) == 2, "shut1 R8 code", int'(err_code), 2);
    chk(int'(count) == 0 && frames == 1, "shut1 R8 count", int'(count), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule